// File: doc/BRIEF.md
# SPI shift-clock prescaler with two field formats

This block sits next to an SPI master that runs from the core clock. It turns the prescale field of the master's configuration register into `half_tick`, a strobe that fires once per half period of the serial clock. The master toggles SCK on every strobe, so it can form both the rising and the falling edge from one pulse train. `half_phase` tells the master which half of the SCK period is now running. Software computes the field from a target frequency; this block only decodes the field and counts.

A parameter picks one of two field formats. The legacy format allows only even divisors from 4 to 30. The extended format encodes the divisor as a 4-bit mantissa times a power of two. The exponent of the extended format is split: its low bit sits in field bit 4 and its upper two bits sit in field bits 7:6. Field bit 5 lies between them, belongs to an unrelated mode setting and is ignored here. A second parameter sets the smallest divisor allowed, which is 4 or 15.

The field is taken into the block only while the master reports idle, so a word never sees its rate change. Every word start restarts the count, so the first SCK edge always comes a fixed half period after the start.

Top module: `spi_sck_prescaler`

## Requirements
- R1: After reset `active_div` equals MIN_DIV, and `half_tick` and `half_phase` are 0.
- R2: In the extended format, with mantissa m = field[3:0] and exponent e = {field[7], field[6], field[4]} (field[4] is the exponent LSB), the divisor is m × 2^e.
- R3: In the extended format, field bit 5 has no effect on `active_div`.
- R4: In the legacy format, a field with bit 4 set gives the divisor 2 × field[3:0]. Field bits 7:5 have no effect.
- R5: A decoded divisor below MIN_DIV becomes MIN_DIV. This covers a mantissa of 0, and any legacy field below 0x12 or with bit 4 clear.
- R6: `active_div` takes the decoded field on the clock edge that closes a cycle with `bus_idle` high. While `bus_idle` is low, `active_div` does not change.
- R7: While a word runs, the half periods alternate. The first half period after a restart is floor(div/2) cycles, and the next is ceil(div/2) cycles. `half_phase` toggles after each strobe, so an odd divisor still gives the exact average rate.
- R8: A cycle with `word_start` high and `bus_idle` low produces no strobe. It clears `half_phase`. The first strobe then comes floor(div/2) cycles after that cycle.
- R9: While `bus_idle` is high, `half_tick` is 0 and `half_phase` returns to 0.
- R10: In the extended format, the largest divisor is 1920 (field 0xFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prescale_field | input | 8 | Prescale field from the configuration register |
| bus_idle | input | 1 | High while the master has no word in progress; the field is sampled while this is high |
| word_start | input | 1 | One-cycle pulse in the first cycle of a word; restarts the half-period count |
| half_tick | output | 1 | One-cycle strobe at twice the SCK rate |
| half_phase | output | 1 | 0 during the first half of an SCK period, 1 during the second |
| active_div | output | DIV_W | Divisor now in use (DIV_W is 11 for the extended format, 5 for the legacy format) |

## Verification
The bench loads fields that separate the two formats:
- a field whose exponent sits only in bit 4, only in bits 7:6, or in both, which exposes a mis-wired split exponent;
- the same mantissa with and without bit 5, to show the unrelated bit is dropped;
- a zero mantissa and small legacy codes, which must clamp to 4 for one instance and to 15 for the other.

Odd divisors (5, 7, 15) show that the floor half comes before the ceiling half. Even divisors must give equal halves. Changing the field in the middle of a word, and pulsing `word_start` again in the middle of a word, separate a rate that is held from one that is taken early. They also show that the count restarts from zero. The largest code, 0xFF, runs a 1920-cycle period to show that the wide counter does not wrap.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic {
    FMT_LEGACY   = 1'b0,
    FMT_EXTENDED = 1'b1
  } psc_fmt_e;

  localparam int FIELD_W     = 8;
  localparam int EXT_MAX_DIV = 15 * 128;
  localparam int LEG_MAX_DIV = 30;
endpackage

// File: rtl/psc_decode.sv
module psc_decode
  import psc_pkg::*;
#(
  parameter psc_fmt_e FMT     = FMT_EXTENDED,
  parameter int       MIN_DIV = 4,
  parameter int       DIV_W   = 11
) (
  input  logic [FIELD_W-1:0] field,
  output logic [DIV_W-1:0]   div
);
  logic [DIV_W-1:0] raw;

  generate
    if (FMT == FMT_EXTENDED) begin : g_ext
      logic [3:0] mant;
      logic [2:0] expo;
      logic       unused_mode_bit;
      assign mant            = field[3:0];
      assign expo            = {field[7:6], field[4]};
      assign unused_mode_bit = field[5];
      assign raw             = DIV_W'(mant) << expo;
    end else begin : g_leg
      logic       unused_hi;
      assign unused_hi = ^field[7:5];
      // field = 0x10 + div/2, so a clear bit 4 is not a valid code
      assign raw = field[4] ? DIV_W'({field[3:0], 1'b0}) : '0;
    end
  endgenerate

  assign div = (raw < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : raw;
endmodule

// File: rtl/psc_hold.sv
module psc_hold #(
  parameter int MIN_DIV = 4,
  parameter int DIV_W   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic [DIV_W-1:0] div_in,
  output logic [DIV_W-1:0] div_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= DIV_W'(MIN_DIV);
    else if (idle) div_q <= div_in;
  end
endmodule

// File: rtl/psc_halfgen.sv
module psc_halfgen #(
  parameter int DIV_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             phase
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half_lo;
  logic [DIV_W-1:0] half_hi;
  logic [DIV_W-1:0] target;

  assign half_lo = div >> 1;
  assign half_hi = div - half_lo;
  assign target  = phase ? half_hi : half_lo;
  assign tick    = !idle && !start && (cnt == target - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (idle || start) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler
  import psc_pkg::*;
#(
  parameter psc_fmt_e FMT     = FMT_EXTENDED,
  parameter int       MIN_DIV = 4,
  localparam int      MAX_DIV = (FMT == FMT_EXTENDED) ? EXT_MAX_DIV : LEG_MAX_DIV,
  localparam int      DIV_W   = $clog2(MAX_DIV + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] prescale_field,
  input  logic               bus_idle,
  input  logic               word_start,
  output logic               half_tick,
  output logic               half_phase,
  output logic [DIV_W-1:0]   active_div
);
  logic [DIV_W-1:0] dec_div;

  psc_decode #(.FMT(FMT), .MIN_DIV(MIN_DIV), .DIV_W(DIV_W)) u_dec (
    .field (prescale_field),
    .div   (dec_div)
  );

  psc_hold #(.MIN_DIV(MIN_DIV), .DIV_W(DIV_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .idle   (bus_idle),
    .div_in (dec_div),
    .div_q  (active_div)
  );

  psc_halfgen #(.DIV_W(DIV_W)) u_gen (
    .clk   (clk),
    .rst_n (rst_n),
    .idle  (bus_idle),
    .start (word_start),
    .div   (active_div),
    .tick  (half_tick),
    .phase (half_phase)
  );
endmodule

// File: rtl/psc_chk.sv
module psc_chk #(
  parameter int MIN_DIV = 4,
  parameter int MAX_DIV = 1920,
  parameter int DIV_W   = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_idle,
  input logic             word_start,
  input logic             half_tick,
  input logic             half_phase,
  input logic [DIV_W-1:0] active_div
);
  // R6
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_idle |=> $stable(active_div));
  // R5
  div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_div >= DIV_W'(MIN_DIV));
  // R10
  div_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_div <= DIV_W'(MAX_DIV));
  // R7
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> (half_phase != $past(half_phase)));
  // R8
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |=> !half_phase);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |=> !half_phase);
endmodule

bind spi_sck_prescaler psc_chk #(.MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV), .DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_idle   (bus_idle),
  .word_start (word_start),
  .half_tick  (half_tick),
  .half_phase (half_phase),
  .active_div (active_div)
);

// File: tb/sim_spi_sck_prescaler.sv
module sim_spi_sck_prescaler;
  import psc_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] fld = 8'h00;
  logic idle = 1'b1;
  logic start = 1'b0;
  logic tk0, tk1, tk2, ph0, ph1, ph2;
  logic [10:0] ad0, ad2;
  logic [4:0]  ad1;
  int vectors = 0;
  int misses = 0;
  int m_div[3], m_left[3];
  bit m_ph[3];
  bit s_tk0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sck_prescaler #(.FMT(FMT_EXTENDED), .MIN_DIV(4)) u0 (
    .clk(clk), .rst_n(rst_n), .prescale_field(fld), .bus_idle(idle),
    .word_start(start), .half_tick(tk0), .half_phase(ph0), .active_div(ad0));
  spi_sck_prescaler #(.FMT(FMT_LEGACY), .MIN_DIV(4)) u1 (
    .clk(clk), .rst_n(rst_n), .prescale_field(fld), .bus_idle(idle),
    .word_start(start), .half_tick(tk1), .half_phase(ph1), .active_div(ad1));
  spi_sck_prescaler #(.FMT(FMT_EXTENDED), .MIN_DIV(15)) u2 (
    .clk(clk), .rst_n(rst_n), .prescale_field(fld), .bus_idle(idle),
    .word_start(start), .half_tick(tk2), .half_phase(ph2), .active_div(ad2));

  function automatic int min_of(int k);
    return (k == 2) ? 15 : 4;
  endfunction

  function automatic int decode(int k, logic [7:0] f);
    int d;
    if (k != 1) d = int'(f[3:0]) * (1 << int'({f[7:6], f[4]}));
    else        d = f[4] ? 2 * int'(f[3:0]) : 0;
    if (d < min_of(k)) d = min_of(k);
    return d;
  endfunction

  function automatic int act(int k);
    return (k == 0) ? int'(ad0) : (k == 1) ? int'(ad1) : int'(ad2);
  endfunction
  function automatic int tick_of(int k);
    return (k == 0) ? int'(tk0) : (k == 1) ? int'(tk1) : int'(tk2);
  endfunction
  function automatic int ph_of(int k);
    return (k == 0) ? int'(ph0) : (k == 1) ? int'(ph1) : int'(ph2);
  endfunction

  task automatic check(string req, int k, int actual, int expected);
    vectors++;
    if (actual != expected) begin
      misses++;
      $display("FAIL %s unit u%0d at %0t: actual=%0d expected=%0d", req, k, $time, actual, expected);
    end
  endtask

  // called just after a falling edge with inputs applied
  task automatic step();
    #(CLK_PERIOD/2 - 1);
    s_tk0 = tk0;
    for (int k = 0; k < 3; k++) begin
      bit exp_tick;
      exp_tick = !idle && !start && (m_left[k] == 1);
      check(idle ? "R9 strobe" : "R7 strobe", k, tick_of(k), int'(exp_tick));
      check("R7 phase", k, ph_of(k), int'(m_ph[k]));
      check("R6 divisor", k, act(k), m_div[k]);
      if (idle) begin
        m_div[k] = decode(k, fld);
        m_ph[k] = 0;
        m_left[k] = m_div[k] / 2;
      end else if (start) begin
        m_ph[k] = 0;
        m_left[k] = m_div[k] / 2;
      end else if (exp_tick) begin
        m_ph[k] = !m_ph[k];
        m_left[k] = m_ph[k] ? (m_div[k] - m_div[k] / 2) : (m_div[k] / 2);
      end else begin
        m_left[k] = m_left[k] - 1;
      end
    end
    @(negedge clk);
  endtask

  task automatic load(logic [7:0] f);
    fld = f; idle = 1'b1; start = 1'b0;
    step();
    step();
  endtask

  task automatic run_word(int n, logic [7:0] mid_field, bit restart_mid);
    int first;
    int mx;
    first = -1;
    mx = (m_div[0] > m_div[2]) ? m_div[0] : m_div[2];
    if (n == 0) n = 3 * mx + 6;
    idle = 1'b0; start = 1'b1;
    step();
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i == n / 2) fld = mid_field;
      if (restart_mid && i == n / 2 + 1) start = 1'b1;
      step();
      start = 1'b0;
      if (s_tk0 && first < 0) first = i + 1;
    end
    // R8: first strobe a floor half period after the start cycle
    check("R8 first edge", 0, first, m_div[0] / 2);
    // R6: mid-word field change not taken
    check("R6 held", 0, int'(ad0), m_div[0]);
    idle = 1'b1;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    misses++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) begin
      m_div[k] = min_of(k); m_ph[k] = 0; m_left[k] = min_of(k) / 2;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", 0, int'(ad0), 4);
    check("R1", 1, int'(ad1), 4);
    check("R1", 2, int'(ad2), 15);
    check("R1", 0, int'(tk0) + int'(ph0), 0);
    rst_n = 1'b1;
    step();

    load(8'h12);
    check("R2", 0, int'(ad0), 4);
    check("R5", 2, int'(ad2), 15);
    check("R4", 1, int'(ad1), 4);
    run_word(0, 8'h7F, 1'b0);

    load(8'h05);
    check("R2", 0, int'(ad0), 5);
    run_word(0, 8'h00, 1'b1);
    load(8'h25);
    check("R3", 0, int'(ad0), 5);
    run_word(0, 8'h33, 1'b0);

    load(8'h07);
    check("R2", 0, int'(ad0), 7);
    check("R5", 1, int'(ad1), 4);
    run_word(0, 8'h1F, 1'b1);

    load(8'h00);
    check("R5", 0, int'(ad0), 4);
    check("R5", 2, int'(ad2), 15);
    run_word(0, 8'hFF, 1'b0);

    load(8'h4A);
    check("R2", 0, int'(ad0), 40);
    check("R5", 1, int'(ad1), 4);
    run_word(0, 8'h12, 1'b1);

    load(8'h83);
    check("R2", 0, int'(ad0), 48);
    run_word(0, 8'h01, 1'b0);

    load(8'h11);
    check("R5", 1, int'(ad1), 4);
    load(8'h1F);
    check("R2", 0, int'(ad0), 30);
    check("R4", 1, int'(ad1), 30);
    run_word(0, 8'h0F, 1'b1);

    load(8'hFF);
    check("R10", 0, int'(ad0), 1920);
    check("R4", 1, int'(ad1), 30);
    run_word(0, 8'h12, 1'b0);

    load(8'h0F);
    check("R2", 0, int'(ad0), 15);
    run_word(41, 8'hFF, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule